// File: doc/BRIEF.md
# Infrared Remote Transmit Modulator

This block drives the LED of an infrared remote-control transmitter. It takes code bytes from an external transmit FIFO and turns them into a serial bit string. Each byte is either eight raw bits or one run-length code, chosen by a configuration input. The bit string runs at a rate set by a programmable baud divisor. No start, stop or parity bits are added. A 1 bit leaves the LED dark. A 0 bit lights it with pulses of a subcarrier whose period and high time are counted in system clocks.

Software builds the protocol-level code and feeds it through the FIFO. The FIFO storage, the DMA engine and the register decode are outside the block. A transmission starts on its own when the block is idle and the FIFO holds data. It ends cleanly on the byte that carries an end-of-transmission or terminal-count marker. If the FIFO runs dry before that, the block raises a sticky underrun flag, and this flag stops the next transmission until software clears it. A two-bit mode input selects the modulation: continuous pulses during every run of 0 bits, or a single burst of 6 or 8 pulses after each 1-to-0 edge.

Top module: `irtx_mod`

## Requirements
- R1: While idle, with the FIFO non-empty and underrun clear, the block asserts `fifo_pop_o` for one cycle, enters the busy state, and puts the first bit of the byte on the line from the next cycle on.
- R2: In raw mode (`rl_mode_i`=0) a byte gives 8 bits, least-significant bit first. Each bit lasts max(`baud_div_i`,1) clocks, and no framing bits are inserted.
- R3: In run-length mode (`rl_mode_i`=1) bit 7 of the byte is the line level and bits 6:0 hold the count minus one, so the level lasts 1 to 128 bit periods.
- R4: The next byte is popped in the final clock of the current byte, so consecutive bytes form a gap-free bit string and a 0 run can cross a byte boundary.
- R5: A byte popped while `eot_i` or `tc_i` is high is the last one. After its final bit the block goes idle with underrun clear.
- R6: If a byte that is not the last one ends while the FIFO is empty, `underrun_o` is set and the block goes idle. While `underrun_o` is set no byte is popped. Only `urun_clr_i` clears it, and a new underrun wins over a clear in the same cycle.
- R7: The LED is low during every 1 bit and while the block is idle.
- R8: In continuous mode (`mod_mode_i` 00 or 11), counting clocks k from the start of a 0 run, the LED is high when k mod P is below H. Here P = max(`sc_period_i`,1) and H = min(`sc_high_i`,P).
- R9: In burst mode (`mod_mode_i`=01 gives 6 pulses, 10 gives 8 pulses) the LED follows the R8 pattern only while k/P is below the burst count. After that it stays dark for the rest of the 0 run.
- R10: A 0 run shorter than the burst ends the burst early, and each new 1-to-0 edge starts a new burst from pulse zero.
- R11: A high time larger than the period is clamped to the period, so the LED stays on for the whole 0 run. A high time of 0 gives no pulses.
- R12: After reset the LED is low, the block is idle, underrun is clear and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty_i | input | 1 | Transmit FIFO holds no byte |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO |
| eot_i | input | 1 | End-of-transmission marker for the head byte |
| tc_i | input | 1 | DMA terminal count for the head byte |
| fifo_pop_o | output | 1 | Takes the head byte at this clock edge |
| rl_mode_i | input | 1 | 0: raw bit string, 1: run-length code |
| baud_div_i | input | DIV_W | Bit period in clocks (0 acts as 1) |
| mod_mode_i | input | 2 | 00/11 continuous, 01 six-pulse, 10 eight-pulse |
| sc_period_i | input | SC_W | Subcarrier period in clocks (0 acts as 1) |
| sc_high_i | input | SC_W | Subcarrier high time in clocks |
| urun_clr_i | input | 1 | Clears the underrun flag |
| led_o | output | 1 | Modulated LED drive, high means lit |
| busy_o | output | 1 | Transmission in progress |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench compares the LED clock by clock against a model of each stream. It checks raw bytes whose zeros cross byte boundaries, which tells LSB-first order and seamless chaining apart from gaps or reversed order. It checks run-length codes with long and short zero runs under 8-pulse and 6-pulse modes, which separates a burst that stops at its count from one cut short by a returning 1. Further streams use a high time above the period and a zero high time, and compare an end-of-transmission marker with a terminal count. A stream without any end marker checks that underrun is raised, that the waiting byte is held back, and that transmission resumes after the clear.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
    typedef enum logic [1:0] {
        MOD_CONT     = 2'b00,
        MOD_SIX      = 2'b01,
        MOD_EIGHT    = 2'b10,
        MOD_CONT_ALT = 2'b11
    } mod_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tx_state_e;
endpackage

// File: rtl/irtx_serializer.sv
module irtx_serializer
    import irtx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty_i,
    input  logic [7:0]       fifo_data_i,
    input  logic             eot_i,
    input  logic             tc_i,
    input  logic             rl_mode_i,
    input  logic [DIV_W-1:0] baud_div_i,
    input  logic             urun_clr_i,
    output logic             fifo_pop_o,
    output logic             bit_o,
    output logic             busy_o,
    output logic             underrun_o
);
    localparam int CNT_W = 7;

    typedef struct packed {
        tx_state_e        st;
        logic [7:0]       sh;
        logic             rl;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] baud;
        logic             last;
        logic             urun;
    } ser_t;

    ser_t q, d;
    logic [DIV_W-1:0] per_m1;
    logic bit_end, byte_end, load;

    always_comb begin
        per_m1   = (baud_div_i == '0) ? '0 : baud_div_i - 1'b1;
        bit_end  = (q.st == ST_RUN) && (q.baud == per_m1);
        byte_end = bit_end && (q.cnt == '0);
        load     = ((q.st == ST_IDLE) && !fifo_empty_i && !q.urun) ||
                   (byte_end && !q.last && !fifo_empty_i);

        d = q;
        if (urun_clr_i) d.urun = 1'b0;

        if (bit_end) begin
            d.baud = '0;
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
                if (!q.rl) d.sh = q.sh >> 1;
            end
        end else if (q.st == ST_RUN) begin
            d.baud = q.baud + 1'b1;
        end

        if (byte_end) begin
            d.st = ST_IDLE;
            if (!q.last && fifo_empty_i) d.urun = 1'b1;
        end

        if (load) begin
            d.st   = ST_RUN;
            d.sh   = fifo_data_i;
            d.rl   = rl_mode_i;
            d.cnt  = rl_mode_i ? fifo_data_i[CNT_W-1:0] : CNT_W'(7);
            d.baud = '0;
            d.last = eot_i | tc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sh: '0, rl: 1'b0, cnt: '0, baud: '0, last: 1'b0, urun: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign fifo_pop_o = load;
    assign bit_o      = (q.st == ST_RUN) ? (q.rl ? q.sh[7] : q.sh[0]) : 1'b1;
    assign busy_o     = (q.st == ST_RUN);
    assign underrun_o = q.urun;
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
    import irtx_pkg::*;
#(
    parameter int SC_W      = 8,
    parameter int MAX_BURST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_i,
    input  logic [1:0]      mode_i,
    input  logic [SC_W-1:0] sc_period_i,
    input  logic [SC_W-1:0] sc_high_i,
    output logic            led_o
);
    localparam int PC_W = $clog2(MAX_BURST + 1) + 1;
    localparam logic [PC_W-1:0] PC_MAX = '1;
    localparam logic [PC_W-1:0] LIM_SIX   = PC_W'(6);
    localparam logic [PC_W-1:0] LIM_EIGHT = PC_W'(8);

    typedef struct packed {
        logic [SC_W-1:0] sc;
        logic [PC_W-1:0] pc;
    } car_t;

    car_t q, d;
    logic [SC_W-1:0] per_eff, per_m1, hi_eff;
    logic [PC_W-1:0] limit;
    logic burst_ok;

    always_comb begin
        per_eff = (sc_period_i == '0) ? SC_W'(1) : sc_period_i;
        per_m1  = per_eff - 1'b1;
        hi_eff  = (sc_high_i > per_eff) ? per_eff : sc_high_i;
        case (mod_mode_e'(mode_i))
            MOD_SIX:   limit = LIM_SIX;
            MOD_EIGHT: limit = LIM_EIGHT;
            default:   limit = '0;
        endcase
        burst_ok = (limit == '0) || (q.pc < limit);

        d = q;
        if (bit_i) begin
            d.sc = '0;
            d.pc = '0;
        end else if (q.sc == per_m1) begin
            d.sc = '0;
            if (q.pc != PC_MAX) d.pc = q.pc + 1'b1;
        end else begin
            d.sc = q.sc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign led_o = !bit_i && (q.sc < hi_eff) && burst_ok;
endmodule

// File: rtl/irtx_mod.sv
module irtx_mod
    import irtx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int SC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty_i,
    input  logic [7:0]       fifo_data_i,
    input  logic             eot_i,
    input  logic             tc_i,
    output logic             fifo_pop_o,
    input  logic             rl_mode_i,
    input  logic [DIV_W-1:0] baud_div_i,
    input  logic [1:0]       mod_mode_i,
    input  logic [SC_W-1:0]  sc_period_i,
    input  logic [SC_W-1:0]  sc_high_i,
    input  logic             urun_clr_i,
    output logic             led_o,
    output logic             busy_o,
    output logic             underrun_o
);
    logic ser_bit;

    irtx_serializer #(.DIV_W(DIV_W)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .eot_i        (eot_i),
        .tc_i         (tc_i),
        .rl_mode_i    (rl_mode_i),
        .baud_div_i   (baud_div_i),
        .urun_clr_i   (urun_clr_i),
        .fifo_pop_o   (fifo_pop_o),
        .bit_o        (ser_bit),
        .busy_o       (busy_o),
        .underrun_o   (underrun_o)
    );

    irtx_carrier #(.SC_W(SC_W), .MAX_BURST(8)) u_car (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_i       (ser_bit),
        .mode_i      (mod_mode_i),
        .sc_period_i (sc_period_i),
        .sc_high_i   (sc_high_i),
        .led_o       (led_o)
    );
endmodule

// File: rtl/irtx_chk.sv
module irtx_chk #(
    parameter int SC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fifo_empty_i,
    input logic            fifo_pop_o,
    input logic            led_o,
    input logic            busy_o,
    input logic            underrun_o,
    input logic            urun_clr_i,
    input logic            bit_s,
    input logic [SC_W-1:0] sc_high_i
);
    p_pop_needs_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> !fifo_empty_i);

    p_urun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_o && !urun_clr_i) |=> underrun_o);

    p_urun_blocks_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> !fifo_pop_o);

    p_one_bit_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_s |-> !led_o);

    p_idle_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !led_o);

    p_zero_high_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_high_i == '0) |-> !led_o);
endmodule

bind irtx_mod irtx_chk #(.SC_W(SC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty_i (fifo_empty_i),
    .fifo_pop_o   (fifo_pop_o),
    .led_o        (led_o),
    .busy_o       (busy_o),
    .underrun_o   (underrun_o),
    .urun_clr_i   (urun_clr_i),
    .bit_s        (ser_bit),
    .sc_high_i    (sc_high_i)
);

// File: tb/tb_irtx_mod.sv
module tb_irtx_mod;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_empty_i = 1'b1;
    logic [7:0]  fifo_data_i = '0;
    logic        eot_i = 1'b0;
    logic        tc_i = 1'b0;
    logic        rl_mode_i = 1'b0;
    logic [15:0] baud_div_i = 16'd4;
    logic [1:0]  mod_mode_i = 2'b00;
    logic [7:0]  sc_period_i = 8'd3;
    logic [7:0]  sc_high_i = 8'd1;
    logic        urun_clr_i = 1'b0;
    logic        fifo_pop_o, led_o, busy_o, underrun_o;

    irtx_mod dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    bit [9:0] fq[$];
    bit       ex[$];
    string    tag_s = "";
    int       total = 0;
    int       bad = 0;
    bit       take = 1'b0;
    bit       run = 1'b0;

    task automatic check(input bit ok, input string req, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // FIFO model and scoreboard monitor, both at the falling edge
    always @(negedge clk) begin
        if (take) begin
            if (fq.size() > 0) void'(fq.pop_front());
            run = 1'b1;
        end
        if (run) begin
            if (ex.size() > 0) begin
                bit e;
                e = ex.pop_front();
                total++;
                if (led_o !== e || busy_o !== 1'b1) begin
                    bad++;
                    $display("FAIL %s: led=%b busy=%b expected led=%b busy=1", tag_s, led_o, busy_o, e);
                end
            end
            if (ex.size() == 0) run = 1'b0;
        end
        fifo_empty_i = (fq.size() == 0);
        fifo_data_i  = (fq.size() > 0) ? fq[0][7:0] : 8'h00;
        eot_i        = (fq.size() > 0) ? fq[0][8] : 1'b0;
        tc_i         = (fq.size() > 0) ? fq[0][9] : 1'b0;
        #1 take = fifo_pop_o;
    end

    // driver side: push expected LED values for a byte stream
    task automatic expect_bytes(input bit [7:0] b[$], input bit rl);
        int bp, sp, he, lim, k;
        bp  = (baud_div_i == 0) ? 1 : int'(baud_div_i);
        sp  = (sc_period_i == 0) ? 1 : int'(sc_period_i);
        he  = (int'(sc_high_i) > sp) ? sp : int'(sc_high_i);
        lim = (mod_mode_i == 2'b01) ? 6 : (mod_mode_i == 2'b10) ? 8 : 0;
        k = 0;
        foreach (b[i]) begin
            int nb;
            nb = rl ? 1 : 8;
            for (int j = 0; j < nb; j++) begin
                bit lvl;
                int reps;
                lvl  = rl ? b[i][7] : b[i][j];
                reps = rl ? int'(b[i][6:0]) + 1 : 1;
                for (int r = 0; r < reps * bp; r++) begin
                    if (lvl) begin
                        ex.push_back(1'b0);
                        k = 0;
                    end else begin
                        ex.push_back(((k % sp) < he) && (lim == 0 || (k / sp) < lim));
                        k++;
                    end
                end
            end
        end
    endtask

    task automatic load_fifo(input bit [7:0] b[$], input bit eot, input bit tc);
        foreach (b[i]) begin
            bit last;
            last = (i == b.size() - 1);
            fq.push_back({last & tc, last & eot, b[i]});
        end
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (run || ex.size() > 0 || fq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #2;
    endtask

    task automatic send(input bit [7:0] b[$], input bit rl, input bit eot, input bit tc,
                        input string t, input bit exp_urun);
        @(negedge clk);
        #2;
        tag_s = t;
        rl_mode_i = rl;
        expect_bytes(b, rl);
        load_fifo(b, eot, tc);
        wait_done();
        check(busy_o === 1'b0 && led_o === 1'b0, t,
              $sformatf("idle after stream busy=%b led=%b expected 0 0", busy_o, led_o));
        check(underrun_o === exp_urun, t,
              $sformatf("underrun=%b expected %b", underrun_o, exp_urun));
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R12 reset state
        check(led_o === 1'b0 && busy_o === 1'b0 && underrun_o === 1'b0 && fifo_pop_o === 1'b0,
              "R12", $sformatf("reset led=%b busy=%b urun=%b pop=%b expected 0000",
                               led_o, busy_o, underrun_o, fifo_pop_o));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R5 R7 R8: single raw byte, continuous mode, eot marker
        baud_div_i = 16'd4; sc_period_i = 8'd3; sc_high_i = 8'd1; mod_mode_i = 2'b00;
        send('{8'hA5}, 1'b0, 1'b1, 1'b0, "R1 R2 R5 R7 R8 raw single", 1'b0);

        // R4 R5: zeros crossing a byte boundary, terminal count ends it
        baud_div_i = 16'd3; sc_period_i = 8'd5; sc_high_i = 8'd2; mod_mode_i = 2'b11;
        send('{8'h00, 8'hF0, 8'h3C}, 1'b0, 1'b0, 1'b1, "R4 R5 R8 raw chain tc", 1'b0);

        // R3 R9 R10: run-length, eight-pulse bursts, long and short zero runs
        baud_div_i = 16'd2; sc_period_i = 8'd3; sc_high_i = 8'd1; mod_mode_i = 2'b10;
        send('{8'h13, 8'h82, 8'h01, 8'h80, 8'h0A}, 1'b1, 1'b1, 1'b0, "R3 R9 R10 rl eight", 1'b0);

        // R9 R10: six-pulse bursts on raw bits, divisor 0 acts as 1
        baud_div_i = 16'd0; sc_period_i = 8'd2; sc_high_i = 8'd1; mod_mode_i = 2'b01;
        send('{8'h01, 8'hF0, 8'h00, 8'h00}, 1'b0, 1'b1, 1'b0, "R2 R9 R10 raw six", 1'b0);

        // R11: high time clamped to period, period 0 acts as 1
        baud_div_i = 16'd3; sc_period_i = 8'd4; sc_high_i = 8'd9; mod_mode_i = 2'b00;
        send('{8'h66}, 1'b0, 1'b1, 1'b0, "R11 clamp", 1'b0);
        sc_period_i = 8'd0; sc_high_i = 8'd1;
        send('{8'h0F}, 1'b0, 1'b1, 1'b0, "R11 period zero", 1'b0);
        sc_period_i = 8'd4; sc_high_i = 8'd0;
        send('{8'h85, 8'h03}, 1'b1, 1'b1, 1'b0, "R11 zero high", 1'b0);

        // R6: no end marker gives underrun
        baud_div_i = 16'd2; sc_period_i = 8'd3; sc_high_i = 8'd2; mod_mode_i = 2'b00;
        send('{8'h5A, 8'hC3}, 1'b0, 1'b0, 1'b0, "R6 underrun raise", 1'b1);

        // R6: byte waits while underrun is set
        @(negedge clk);
        #2;
        fq.push_back({1'b0, 1'b1, 8'h0F});
        repeat (10) @(negedge clk);
        #2;
        check(fq.size() == 1, "R6", $sformatf("fifo depth=%0d expected 1 while underrun", fq.size()));
        check(led_o === 1'b0 && busy_o === 1'b0, "R6",
              $sformatf("led=%b busy=%b expected 0 0 while underrun", led_o, busy_o));

        // R6: clear lets the waiting byte go out
        tag_s = "R6 resume after clear";
        rl_mode_i = 1'b0;
        expect_bytes('{8'h0F}, 1'b0);
        urun_clr_i = 1'b1;
        @(negedge clk);
        #2;
        urun_clr_i = 1'b0;
        wait_done();
        check(underrun_o === 1'b0 && busy_o === 1'b0, "R6",
              $sformatf("after clear urun=%b busy=%b expected 0 0", underrun_o, busy_o));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule